// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Event Interrupts

This block is a general-purpose pin controller for sixteen pins. It sits on a small memory-mapped register bus that carries 16-bit words, with one bit per pin. Software chooses per pin whether the pin drives (output enable) or listens. Output levels change only by writing a word to a set port or a clear port. Incoming pin levels are resynchronised into the clock domain before anything looks at them.

Every pin can raise an event. An event is either a level of selectable polarity or a rising and/or falling transition of the synchronised input. Events accumulate in an internal pending register whether or not they are gated. A pending bit is visible in the status word only when its mask bit is 0 and its enable bit is 1, and the single interrupt line is the OR of the visible bits. Software acknowledges events by writing ones to an acknowledge port.

Register offsets are byte offsets: 0x00 direction, 0x04 trigger kind, 0x08 level polarity, 0x0C rising enable, 0x10 falling enable, 0x14 input levels, 0x18 set port, 0x1C clear port, 0x20 output latch, 0x28 mask, 0x2C enable, 0x30 gated status, 0x34 acknowledge. Reads are combinational from `bus_addr`. A write takes effect at the clock edge on which `bus_wr` is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction, output latch, trigger kind, polarity, rising-enable, falling-enable, enable and pending state are all zero. The mask (0x28) is 0xFFFF and `irq` is low.
- R2: The direction word at 0x00 reads back as written and drives `pin_oe`. A 1 bit makes the pin an output.
- R3: Ones written to 0x18 set the matching output latch bits. Ones written to 0x1C clear them. Zero bits leave the latch unchanged. The latch appears on `pin_out` and reads back at 0x20.
- R4: A read of 0x14 returns `pin_in` as sampled two clock edges earlier.
- R5: A pin whose bit at 0x04 is 1 is in level mode. It becomes pending at every edge where its synchronised level equals its polarity bit at 0x08 (1 = high active, 0 = low active).
- R6: A pin whose bit at 0x04 is 0 is in edge mode. It becomes pending one edge after its synchronised value rises (if its 0x0C bit is set) or falls (if its 0x10 bit is set). Both enables together arm both transitions. With neither set the pin never becomes pending.
- R7: A read of 0x30 returns pending AND NOT mask AND enable. `irq` is high exactly when that word is non-zero, so an all-ones mask keeps `irq` low.
- R8: Events latch into the pending state even while gated off. Clearing the mask bit later exposes an event that was recorded earlier.
- R9: Ones written to 0x34 clear the matching pending bits. An edge-mode pending bit stays set until acknowledged. An edge detected on the same edge as its acknowledge is kept.
- R10: A level-mode pin that is acknowledged while its level is still active reads not pending for exactly one cycle and is pending again on the next edge.
- R11: Writes to 0x14, 0x30, 0x20 and to unmapped offsets change nothing. Reads of 0x18, 0x1C, 0x34 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data, one bit per pin |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output latch |
| pin_oe | output | 16 | Per-pin output enable (direction) |
| irq | output | 1 | Combined interrupt, OR of the gated status |

## Verification
The hardest situation to reach from the ports is an acknowledge that lands on the same edge as a fresh transition on the same pin. The transition must be timed so that it reaches the detector, through two synchroniser flops, on exactly the edge of the acknowledge write. The bench gets there with a both-edge pin. It toggles the pin, waits one cycle and then issues the acknowledge, so the write lands on the third edge after the change. A related timing case is the single-cycle drop of a level-mode pin after its acknowledge, which the bench checks at the two negative edges around that write. A per-cycle behavioural model, driven also by long random streams of writes and pin changes, covers the remaining orderings.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [7:0] {
    OFS_DIR  = 8'h00,
    OFS_KIND = 8'h04,
    OFS_POL  = 8'h08,
    OFS_RISE = 8'h0C,
    OFS_FALL = 8'h10,
    OFS_IN   = 8'h14,
    OFS_SET  = 8'h18,
    OFS_CLR  = 8'h1C,
    OFS_OUT  = 8'h20,
    OFS_MASK = 8'h28,
    OFS_EN   = 8'h2C,
    OFS_STAT = 8'h30,
    OFS_ACK  = 8'h34
  } reg_ofs_e;

  // per-pin trigger configuration
  typedef struct packed {
    logic lvl;   // 1: level mode, 0: edge mode
    logic pol;   // level polarity, 1 = high active
    logic rise;  // edge mode: rising transition arms
    logic fall;  // edge mode: falling transition arms
  } trig_cfg_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int NPIN   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] sync_q,
  output logic [NPIN-1:0] prev_q
);
  localparam int CW = $clog2(STAGES + 1) + 1;

  logic [NPIN-1:0] stage_q [STAGES];
  logic [NPIN-1:0] stage_d [STAGES];
  logic [NPIN-1:0] prev_d;

  always_comb begin
    stage_d[0] = pin_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
    prev_d = stage_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
      prev_q <= prev_d;
    end
  end

  assign sync_q = stage_q[STAGES-1];

  // checker: cycles since reset, saturating at STAGES
  logic [CW-1:0] since_rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst_q <= '0;
    else if (since_rst_q != CW'(STAGES)) since_rst_q <= since_rst_q + 1'b1;
  end

  // R4: synchronised value is the pin level STAGES edges earlier
  p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q == CW'(STAGES)) |-> (sync_q == $past(pin_in, STAGES)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic      [NPIN-1:0] sync_q,
  input  logic      [NPIN-1:0] prev_q,
  input  trig_cfg_t [NPIN-1:0] cfg,
  input  logic      [NPIN-1:0] ack_bits,
  output logic      [NPIN-1:0] pend_q
);
  logic [NPIN-1:0] pend_d;
  logic [NPIN-1:0] lvl_vec;
  logic [NPIN-1:0] armed_vec;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic lvl_hit, rise_hit, fall_hit, edge_hit;
    assign lvl_hit  = cfg[g].lvl && (sync_q[g] == cfg[g].pol);
    assign rise_hit = cfg[g].rise && sync_q[g] && !prev_q[g];
    assign fall_hit = cfg[g].fall && !sync_q[g] && prev_q[g];
    assign edge_hit = !cfg[g].lvl && (rise_hit || fall_hit);
    // an edge on the acknowledge cycle survives; a level re-arms one cycle later
    assign pend_d[g] = (pend_q[g] && !ack_bits[g]) || edge_hit ||
                       (lvl_hit && !ack_bits[g]);
    assign lvl_vec[g]   = cfg[g].lvl;
    assign armed_vec[g] = cfg[g].rise || cfg[g].fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R9: an edge-mode pending bit holds until acknowledged
  p_edge_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~$past(ack_bits) & ~$past(lvl_vec)) & ~pend_q) == '0);

  // R6: an edge-mode pin with no transition enabled never becomes pending
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(pend_q) & ~$past(lvl_vec) & ~$past(armed_vec)) & pend_q) == '0);

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int AW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic      [AW-1:0]   bus_addr,
  input  logic      [NPIN-1:0] bus_wdata,
  output logic      [NPIN-1:0] bus_rdata,
  input  logic      [NPIN-1:0] sync_q,
  input  logic      [NPIN-1:0] pend_q,
  output logic      [NPIN-1:0] dir_q,
  output logic      [NPIN-1:0] out_q,
  output logic      [NPIN-1:0] mask_q,
  output logic      [NPIN-1:0] status,
  output logic      [NPIN-1:0] ack_bits,
  output trig_cfg_t [NPIN-1:0] cfg
);
  logic hit_dir, hit_kind, hit_pol, hit_rise, hit_fall;
  logic hit_set, hit_clr, hit_mask, hit_en, hit_ack;

  logic [NPIN-1:0] kind_q, pol_q, rise_q, fall_q, en_q;
  logic [NPIN-1:0] out_d;
  logic            out_ce;

  // address decode
  always_comb begin
    hit_dir  = bus_wr && (bus_addr == AW'(OFS_DIR));
    hit_kind = bus_wr && (bus_addr == AW'(OFS_KIND));
    hit_pol  = bus_wr && (bus_addr == AW'(OFS_POL));
    hit_rise = bus_wr && (bus_addr == AW'(OFS_RISE));
    hit_fall = bus_wr && (bus_addr == AW'(OFS_FALL));
    hit_set  = bus_wr && (bus_addr == AW'(OFS_SET));
    hit_clr  = bus_wr && (bus_addr == AW'(OFS_CLR));
    hit_mask = bus_wr && (bus_addr == AW'(OFS_MASK));
    hit_en   = bus_wr && (bus_addr == AW'(OFS_EN));
    hit_ack  = bus_wr && (bus_addr == AW'(OFS_ACK));
  end

  // next state of the output latch
  always_comb begin
    out_ce = hit_set || hit_clr;
    if (hit_set) out_d = out_q | bus_wdata;
    else         out_d = out_q & ~bus_wdata;
  end

  assign ack_bits = hit_ack ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      kind_q <= '0;
      pol_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      out_q  <= '0;
      mask_q <= '1;
      en_q   <= '0;
    end else begin
      if (hit_dir)  dir_q  <= bus_wdata;
      if (hit_kind) kind_q <= bus_wdata;
      if (hit_pol)  pol_q  <= bus_wdata;
      if (hit_rise) rise_q <= bus_wdata;
      if (hit_fall) fall_q <= bus_wdata;
      if (out_ce)   out_q  <= out_d;
      if (hit_mask) mask_q <= bus_wdata;
      if (hit_en)   en_q   <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_cfg
    assign cfg[g].lvl  = kind_q[g];
    assign cfg[g].pol  = pol_q[g];
    assign cfg[g].rise = rise_q[g];
    assign cfg[g].fall = fall_q[g];
  end

  assign status = pend_q & ~mask_q & en_q;

  // read mux
  always_comb begin
    case (bus_addr)
      AW'(OFS_DIR):  bus_rdata = dir_q;
      AW'(OFS_KIND): bus_rdata = kind_q;
      AW'(OFS_POL):  bus_rdata = pol_q;
      AW'(OFS_RISE): bus_rdata = rise_q;
      AW'(OFS_FALL): bus_rdata = fall_q;
      AW'(OFS_IN):   bus_rdata = sync_q;
      AW'(OFS_OUT):  bus_rdata = out_q;
      AW'(OFS_MASK): bus_rdata = mask_q;
      AW'(OFS_EN):   bus_rdata = en_q;
      AW'(OFS_STAT): bus_rdata = status;
      default:       bus_rdata = '0;
    endcase
  end

  // R3: set port raises every addressed bit
  p_set_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R3: clear port lowers every addressed bit, leaves others
  p_clr_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> (((out_q & $past(bus_wdata)) == '0) &&
                 ((out_q & ~$past(bus_wdata)) == ($past(out_q) & ~$past(bus_wdata)))));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN   = 16,
  parameter int AW     = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  logic      [NPIN-1:0] sync_q, prev_q, pend_q, ack_bits, status, mask_q;
  trig_cfg_t [NPIN-1:0] cfg;

  gpio_irq_sync #(.NPIN(NPIN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .sync_q(sync_q), .prev_q(prev_q)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .prev_q(prev_q),
    .cfg(cfg), .ack_bits(ack_bits), .pend_q(pend_q)
  );

  gpio_irq_regs #(.NPIN(NPIN), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_q(sync_q),
    .pend_q(pend_q), .dir_q(pin_oe), .out_q(pin_out), .mask_q(mask_q),
    .status(status), .ack_bits(ack_bits), .cfg(cfg)
  );

  assign irq = |status;

  // R2: a direction write appears on the output enables next cycle
  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == AW'(OFS_DIR))) |=> (pin_oe == $past(bus_wdata)));

  // R7: a fully set mask keeps the interrupt line low
  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  // delays in ps; 5000 ps period = 200 MHz
  localparam int HALF = 2500;
  localparam int DRV  = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] bus_rdata, pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  gpio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #HALF clk = ~clk;

  // ---------------- reference model ----------------
  logic [15:0] m_dir, m_out, m_kind, m_pol, m_rise, m_fall, m_mask, m_en, m_pend;
  logic [15:0] m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_out = 0; m_kind = 0; m_pol = 0; m_rise = 0; m_fall = 0;
      m_mask = 16'hFFFF; m_en = 0; m_pend = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      logic [15:0] ack, np;
      ack = (bus_wr && bus_addr == 8'h34) ? bus_wdata : 16'h0;
      for (int i = 0; i < 16; i++) begin
        bit lv, ed;
        lv = m_kind[i] && (m_s2[i] == m_pol[i]);
        ed = !m_kind[i] && ((m_rise[i] && m_s2[i] && !m_s3[i]) ||
                            (m_fall[i] && !m_s2[i] && m_s3[i]));
        np[i] = (m_pend[i] && !ack[i]) || ed || (lv && !ack[i]);
      end
      m_pend = np;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_dir  = bus_wdata;
          8'h04: m_kind = bus_wdata;
          8'h08: m_pol  = bus_wdata;
          8'h0C: m_rise = bus_wdata;
          8'h10: m_fall = bus_wdata;
          8'h18: m_out  = m_out | bus_wdata;
          8'h1C: m_out  = m_out & ~bus_wdata;
          8'h28: m_mask = bus_wdata;
          8'h2C: m_en   = bus_wdata;
          default: ;
        endcase
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  function automatic logic [15:0] m_stat();
    return m_pend & ~m_mask & m_en;
  endfunction

  function automatic logic [15:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return m_dir;
      8'h04: return m_kind;
      8'h08: return m_pol;
      8'h0C: return m_rise;
      8'h10: return m_fall;
      8'h14: return m_s2;
      8'h20: return m_out;
      8'h28: return m_mask;
      8'h2C: return m_en;
      8'h30: return m_stat();
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04, 8'h08: return "R5";
      8'h0C, 8'h10: return "R6";
      8'h14: return "R4";
      8'h20: return "R3";
      8'h28, 8'h2C, 8'h30: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    chk("R2 pin_oe", pin_oe, m_dir);
    chk("R3 pin_out", pin_out, m_out);
    chk("R7 irq", {15'h0, irq}, {15'h0, |m_stat()});
    chk({tag_of(bus_addr), " rdata"}, bus_rdata, m_read(bus_addr));
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); #DRV;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #DRV;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [15:0] exp, string tag);
    @(negedge clk); #DRV;
    bus_addr = a;
    #DRV;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pins(logic [15:0] v);
    @(negedge clk); #DRV;
    pin_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    // R1: reset state
    rd(8'h28, 16'hFFFF, "R1 mask");
    rd(8'h2C, 16'h0000, "R1 enable");
    rd(8'h00, 16'h0000, "R1 direction");
    rd(8'h20, 16'h0000, "R1 out latch");
    chk("R1 irq", {15'h0, irq}, 16'h0);
    // R2: direction
    wr(8'h00, 16'hA5A5);
    chk("R2 oe", pin_oe, 16'hA5A5);
    rd(8'h00, 16'hA5A5, "R2 readback");
    // R3: set/clear ports
    wr(8'h18, 16'h00FF);
    wr(8'h1C, 16'h000F);
    chk("R3 set-clear", pin_out, 16'h00F0);
    wr(8'h18, 16'h0000);
    chk("R3 zero set", pin_out, 16'h00F0);
    rd(8'h20, 16'h00F0, "R3 readback");
    // R4: input sampling
    pins(16'h1234);
    idle(3);
    rd(8'h14, 16'h1234, "R4 input");
    // R11: ignored writes and empty reads
    wr(8'h14, 16'hFFFF);
    wr(8'h20, 16'h0000);
    wr(8'h24, 16'hFFFF);
    rd(8'h14, 16'h1234, "R11 input unchanged");
    rd(8'h20, 16'h00F0, "R11 latch unchanged");
    rd(8'h24, 16'h0000, "R11 unmapped");
    rd(8'h18, 16'h0000, "R11 set port reads zero");
    pins(16'h0000);
    idle(3);
    // R6: rising edge on pin0
    wr(8'h0C, 16'h0001);
    wr(8'h2C, 16'h000F);
    wr(8'h28, 16'hFFF8);
    pins(16'h0001);
    idle(4);
    rd(8'h30, 16'h0001, "R6 rise");
    chk("R7 irq high", {15'h0, irq}, 16'h1);
    pins(16'h0000);
    idle(4);
    rd(8'h30, 16'h0001, "R9 edge holds");
    wr(8'h34, 16'h0001);
    rd(8'h30, 16'h0000, "R9 acked");
    // R6: both edges on pin1, R9 same-cycle edge kept
    wr(8'h0C, 16'h0003);
    wr(8'h10, 16'h0002);
    pins(16'h0002);
    idle(4);
    rd(8'h30, 16'h0002, "R6 both rise");
    pins(16'h0000);
    idle(1);
    wr(8'h34, 16'h0002);
    rd(8'h30, 16'h0002, "R9 edge on ack cycle kept");
    wr(8'h34, 16'h0002);
    rd(8'h30, 16'h0000, "R9 cleared");
    // R5/R10: level low-active on pin2
    wr(8'h04, 16'h0004);
    idle(2);
    rd(8'h30, 16'h0004, "R5 low level");
    wr(8'h34, 16'h0004);
    chk("R10 drop", {15'h0, irq}, 16'h0);
    @(negedge clk);
    chk("R10 rearm", {15'h0, irq}, 16'h1);
    pins(16'h0004);
    idle(3);
    wr(8'h34, 16'h0004);
    idle(1);
    rd(8'h30, 16'h0000, "R5 inactive level");
    // R8: masked event exposed by unmask (pin3 rising)
    wr(8'h04, 16'h0000);
    wr(8'h0C, 16'h0008);
    pins(16'h000C);
    idle(4);
    rd(8'h30, 16'h0000, "R8 gated");
    chk("R8 irq low", {15'h0, irq}, 16'h0);
    wr(8'h28, 16'hFFF0);
    rd(8'h30, 16'h0008, "R8 exposed");
    // R7: full mask blocks
    wr(8'h28, 16'hFFFF);
    chk("R7 mask blocks", {15'h0, irq}, 16'h0);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #DRV;
      case ($urandom_range(0, 3))
        0: begin
          logic [7:0] ofs [15] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                   8'h18, 8'h1C, 8'h20, 8'h28, 8'h2C, 8'h30,
                                   8'h34, 8'h24, 8'h3C};
          bus_wr = 1'b1;
          bus_addr = ofs[$urandom_range(0, 14)];
          bus_wdata = 16'($urandom);
        end
        1: begin bus_wr = 1'b0; pin_in = pin_in ^ (16'(1) << $urandom_range(0, 15)); end
        2: begin bus_wr = 1'b0; pin_in = 16'($urandom); end
        default: begin
          bus_wr = 1'b0;
          bus_addr = 8'($urandom_range(0, 13) * 4);
        end
      endcase
    end
    @(negedge clk); #DRV; bus_wr = 1'b0;
    idle(2);
    finish_run();
  end

endmodule